// File: doc/BRIEF.md
# IDE PIO strobe timing generator

This block produces the active-low read and write command strobes for two ATA channels, each carrying two drives. A host request names a channel, a drive and a direction. While idle, the block accepts the request, picks a timing, drives the matching strobe low for the active count, then holds every strobe high for the recovery count, and then pulses `done` for one cycle. One timing unit is one clock period; with a 30 ns interface clock a count of N stands for N x 30 ns.

A small register port holds one control word and four per-drive timing words. The control word enables each channel and selects, per channel, whether accesses use the programmed per-drive timing or the slow fixed default. A per-channel reset input clears that channel's programmed-timing bit. A drive may enable ready sampling: while its channel's `iordy` input is low during the active phase, the active count pauses. After 256 paused cycles in one access, the block abandons the strobe and reports a timeout.

The state machine has four states. IDLE waits for a request. ACTIVE drives the strobe low. RECOVER keeps the strobes high. FINISH raises `done` for one cycle. IDLE goes to ACTIVE when a request arrives for an enabled channel, and to FINISH when the channel is disabled. ACTIVE goes to RECOVER when the active count runs out or the stretch limit is reached. RECOVER goes to FINISH when the recovery count runs out. FINISH always returns to IDLE.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: A timing word stores the active count minus one in bits 12:8 and the recovery count minus one in bits 4:0. The strobe is low for exactly (bits 12:8)+1 cycles, followed by (bits 4:0)+1 recovery cycles, so each phase spans 1 to 32 cycles.
- R2: The control word is at offset 0x40. Its bit 0 enables channel 0, bit 4 enables channel 1, bit 1 selects programmed timing for channel 0, and bit 5 does the same for channel 1. The timing words sit at 0x44 (ch0 drv0), 0x48 (ch0 drv1), 0x4C (ch1 drv0) and 0x50 (ch1 drv1). Unimplemented bits read as zero. After reset the control word is 0 and every timing word is 0x0909.
- R3: While a channel's programmed-timing bit is clear, every access on that channel uses 0x0909: 10 active cycles, 10 recovery cycles, and ready sampling off.
- R4: A pulse on `chan_rst[c]` clears the programmed-timing bit of channel c and leaves the other channel's bits untouched.
- R5: A request to a disabled channel produces `done` with `err` on the next cycle and asserts no strobe.
- R6: When bit 6 of the selected timing word is set, each active cycle with that channel's `iordy` low pauses the active count. When bit 6 is clear, `iordy` has no effect.
- R7: On the 256th paused cycle of an access, the strobe is released, recovery follows, and `timeout` is raised together with `done`.
- R8: No more than one strobe is low at any time. Strobes are high in IDLE, RECOVER and FINISH. The strobe used is `rd_n` or `wr_n` of the requested channel, chosen by `req_write` (1 = write).
- R9: `done` is high for exactly one cycle, right after the last recovery cycle. `busy` is high from acceptance through that cycle. A request raised while busy is ignored.
- R10: The timing is captured when a request is accepted. A register write made during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| chan_rst | input | 2 | Per-channel reset pulse; clears the programmed-timing bit |
| req_valid | input | 1 | Access request, taken only when idle |
| req_chan | input | 1 | Channel of the request |
| req_drive | input | 1 | Drive of the request |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| iordy | input | 2 | Per-channel device ready, low = pause |
| rd_n | output | 2 | Per-channel read strobe, active low |
| wr_n | output | 2 | Per-channel write strobe, active low |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: the channel was disabled |
| timeout | output | 1 | With `done`: the ready stretch limit was hit |

## Verification
The bench drives both phase counts to their extremes of 1 and 32 cycles. A design with an off-by-one in its count-minus-one decoding would make the strobe or the gap one cycle off from the model. It pauses ready for a few cycles with sampling on and with sampling off, and holds it low long enough to reach the 256-cycle limit. A wrong stall comparison would show up as a timeout one cycle early or late, or as a pause where ready should be ignored. It also clears a programmed-timing bit with a channel reset and raises requests to disabled channels. A design that kept using the programmed word, or that raised a strobe for a disabled channel, would be caught here. Finally, it sends a second request and rewrites a timing word while an access is running. A design that accepts the request or reads timing live would then drive a second strobe or change the strobe length.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RECOVER = 2'd2,
        ST_FINISH  = 2'd3
    } pio_state_e;

    localparam int PHASE_W = 5;

    typedef struct packed {
        logic [PHASE_W-1:0] act_m1;
        logic               rdy_en;
        logic [PHASE_W-1:0] rec_m1;
    } pio_timing_t;

    localparam logic [15:0] SLOW_WORD = 16'h0909;

    function automatic pio_timing_t word_to_timing(input logic [15:0] w);
        pio_timing_t t;
        t.act_m1 = w[12:8];
        t.rdy_en = w[6];
        t.rec_m1 = w[4:0];
        return t;
    endfunction

    function automatic logic [15:0] timing_to_word(input pio_timing_t t);
        return {3'b000, t.act_m1, 1'b0, t.rdy_en, 1'b0, t.rec_m1};
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_strobe_pkg::*;
#(
    parameter int          NUM_CH      = 2,
    parameter int          DRV_PER_CH  = 2,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int unsigned CTRL_OFFSET = 32'h40,
    parameter int unsigned TIM_OFFSET  = 32'h44,
    localparam int         NUM_DRV     = NUM_CH * DRV_PER_CH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_CH-1:0]         chan_rst,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_CH-1:0]         ch_en,
    output logic [NUM_CH-1:0]         ch_fast,
    output pio_timing_t [NUM_DRV-1:0] tim
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);

    logic ctrl_hit;
    assign ctrl_hit = we && (addr == CTRL_ADDR);

    // control bits: enable at 4*c, programmed-timing select at 4*c+1
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_en[c]   <= 1'b0;
                ch_fast[c] <= 1'b0;
            end else begin
                if (ctrl_hit) begin
                    ch_en[c]   <= wdata[4*c];
                    ch_fast[c] <= wdata[4*c+1];
                end
                if (chan_rst[c]) begin
                    ch_fast[c] <= 1'b0;
                end
            end
        end
    end

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_tim
        localparam logic [ADDR_W-1:0] TIM_ADDR = ADDR_W'(TIM_OFFSET + 4 * d);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tim[d] <= word_to_timing(SLOW_WORD);
            end else if (we && (addr == TIM_ADDR)) begin
                tim[d] <= word_to_timing(wdata[15:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            for (int c = 0; c < NUM_CH; c++) begin
                rdata[4*c]   = ch_en[c];
                rdata[4*c+1] = ch_fast[c];
            end
        end
        for (int d = 0; d < NUM_DRV; d++) begin
            if (addr == ADDR_W'(TIM_OFFSET + 4 * d)) begin
                rdata = DATA_W'(timing_to_word(tim[d]));
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_strobe_pkg::*;
#(
    parameter int  NUM_CH     = 2,
    parameter int  DRV_PER_CH = 2,
    localparam int NUM_DRV    = NUM_CH * DRV_PER_CH,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DRV_W      = (DRV_PER_CH > 1) ? $clog2(DRV_PER_CH) : 1
) (
    input  logic [CH_W-1:0]           chan,
    input  logic [DRV_W-1:0]          drive,
    input  logic [NUM_CH-1:0]         ch_fast,
    input  pio_timing_t [NUM_DRV-1:0] tim,
    output pio_timing_t               eff
);

    // drive index: channel in the upper bits, drive in the lower bits
    logic [CH_W+DRV_W-1:0] idx;
    assign idx = {chan, drive};

    always_comb begin
        if (ch_fast[chan]) begin
            eff = tim[idx];
        end else begin
            eff = word_to_timing(SLOW_WORD);
        end
    end

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_strobe_pkg::*;
#(
    parameter int  NUM_CH        = 2,
    parameter int  STRETCH_LIMIT = 256,
    localparam int CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int STALL_W       = $clog2(STRETCH_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_write,
    input  logic [NUM_CH-1:0] ch_en,
    input  pio_timing_t       eff,
    input  logic [NUM_CH-1:0] iordy,
    output logic [NUM_CH-1:0] rd_n,
    output logic [NUM_CH-1:0] wr_n,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              timeout
);

    localparam logic [STALL_W-1:0] STALL_LAST = STALL_W'(STRETCH_LIMIT - 1);

    pio_state_e         state_q, state_d;
    logic [PHASE_W-1:0] cnt_q, cnt_d;
    logic [PHASE_W-1:0] rec_q, rec_d;
    logic [STALL_W-1:0] stall_q, stall_d;
    logic [CH_W-1:0]    chan_q, chan_d;
    logic               wr_q, wr_d;
    logic               rdy_q, rdy_d;
    logic               err_q, err_d;
    logic               tmo_q, tmo_d;
    logic               paused;

    assign paused = rdy_q && !iordy[chan_q];

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rec_d   = rec_q;
        stall_d = stall_q;
        chan_d  = chan_q;
        wr_d    = wr_q;
        rdy_d   = rdy_q;
        err_d   = err_q;
        tmo_d   = tmo_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    chan_d  = req_chan;
                    wr_d    = req_write;
                    stall_d = '0;
                    tmo_d   = 1'b0;
                    if (!ch_en[req_chan]) begin
                        err_d   = 1'b1;
                        state_d = ST_FINISH;
                    end else begin
                        err_d   = 1'b0;
                        cnt_d   = eff.act_m1;
                        rec_d   = eff.rec_m1;
                        rdy_d   = eff.rdy_en;
                        state_d = ST_ACTIVE;
                    end
                end
            end
            ST_ACTIVE: begin
                if (paused) begin
                    if (stall_q == STALL_LAST) begin
                        tmo_d   = 1'b1;
                        cnt_d   = rec_q;
                        state_d = ST_RECOVER;
                    end else begin
                        stall_d = stall_q + STALL_W'(1);
                    end
                end else if (cnt_q == '0) begin
                    cnt_d   = rec_q;
                    state_d = ST_RECOVER;
                end else begin
                    cnt_d = cnt_q - PHASE_W'(1);
                end
            end
            ST_RECOVER: begin
                if (cnt_q == '0) begin
                    state_d = ST_FINISH;
                end else begin
                    cnt_d = cnt_q - PHASE_W'(1);
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rec_q   <= '0;
            stall_q <= '0;
            chan_q  <= '0;
            wr_q    <= 1'b0;
            rdy_q   <= 1'b0;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rec_q   <= rec_d;
            stall_q <= stall_d;
            chan_q  <= chan_d;
            wr_q    <= wr_d;
            rdy_q   <= rdy_d;
            err_q   <= err_d;
            tmo_q   <= tmo_d;
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            rd_n[c] = !((state_q == ST_ACTIVE) && (chan_q == CH_W'(c)) && !wr_q);
            wr_n[c] = !((state_q == ST_ACTIVE) && (chan_q == CH_W'(c)) && wr_q);
        end
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        err     = (state_q == ST_FINISH) && err_q;
        timeout = (state_q == ST_FINISH) && tmo_q;
    end

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter int  NUM_CH        = 2,
    parameter int  DRV_PER_CH    = 2,
    parameter int  ADDR_W        = 8,
    parameter int  DATA_W        = 32,
    parameter int  STRETCH_LIMIT = 256,
    localparam int NUM_DRV       = NUM_CH * DRV_PER_CH,
    localparam int CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DRV_W         = (DRV_PER_CH > 1) ? $clog2(DRV_PER_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NUM_CH-1:0] chan_rst,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic              req_write,
    input  logic [NUM_CH-1:0] iordy,
    output logic [NUM_CH-1:0] rd_n,
    output logic [NUM_CH-1:0] wr_n,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              timeout
);

    logic [NUM_CH-1:0]         ch_en;
    logic [NUM_CH-1:0]         ch_fast;
    pio_timing_t [NUM_DRV-1:0] tim;
    pio_timing_t               eff;

    pio_cfg_regs #(
        .NUM_CH     (NUM_CH),
        .DRV_PER_CH (DRV_PER_CH),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .chan_rst (chan_rst),
        .rdata    (cfg_rdata),
        .ch_en    (ch_en),
        .ch_fast  (ch_fast),
        .tim      (tim)
    );

    pio_timing_sel #(
        .NUM_CH     (NUM_CH),
        .DRV_PER_CH (DRV_PER_CH)
    ) u_sel (
        .chan    (req_chan),
        .drive   (req_drive),
        .ch_fast (ch_fast),
        .tim     (tim),
        .eff     (eff)
    );

    pio_phase_fsm #(
        .NUM_CH        (NUM_CH),
        .STRETCH_LIMIT (STRETCH_LIMIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_write (req_write),
        .ch_en     (ch_en),
        .eff       (eff),
        .iordy     (iordy),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .timeout   (timeout)
    );

endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [NUM_CH-1:0] chan_rst,
    input logic [NUM_CH-1:0] ch_fast,
    input logic [NUM_CH-1:0] rd_n,
    input logic [NUM_CH-1:0] wr_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              timeout
);

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{rd_n, wr_n}) <= 1);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&{rd_n, wr_n}));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(&{rd_n, wr_n}));

    assert_start_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !timeout));

    assert_timeout_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (done && !err));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rst
        assert_chan_reset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            chan_rst[c] |=> !ch_fast[c]);
    end

endmodule

bind ata_pio_strobe_gen pio_strobe_checker #(
    .NUM_CH (NUM_CH)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .chan_rst  (chan_rst),
    .ch_fast   (ch_fast),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .timeout   (timeout)
);

// File: tb/test_ata_pio_strobe_gen.sv
module test_ata_pio_strobe_gen;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 100000;
    localparam int STRETCH         = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  chan_rst = 2'b00;
    logic        req_valid = 1'b0;
    logic [0:0]  req_chan = 1'b0;
    logic [0:0]  req_drive = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  iordy = 2'b11;
    logic [1:0]  rd_n, wr_n;
    logic        busy, done, err, timeout;

    ata_pio_strobe_gen i_ata_pio_strobe_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .chan_rst  (chan_rst),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_drive (req_drive),
        .req_write (req_write),
        .iordy     (iordy),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .timeout   (timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_ctrl;
    bit [15:0] m_tim [4];
    int        m_phase;   // 0 idle, 1 strobe, 2 gap, 3 finish
    int        m_left, m_stall, m_rec, m_ch;
    bit        m_wr, m_rdy, m_err, m_tmo;

    always @(posedge clk) begin : model
        int  w;
        bit  fast;
        if (!rst_n) begin
            m_phase = 0; m_err = 0; m_tmo = 0; m_ctrl = 0;
            for (int i = 0; i < 4; i++) m_tim[i] = 16'h0909;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_ch = int'(req_chan); m_wr = req_write; m_tmo = 0; m_stall = 0;
                    if (!m_ctrl[m_ch * 4]) begin
                        m_err = 1; m_phase = 3;
                    end else begin
                        m_err = 0;
                        fast = m_ctrl[m_ch * 4 + 1];
                        w = fast ? int'(m_tim[m_ch * 2 + int'(req_drive)]) : 'h0909;
                        m_left = ((w >> 8) & 31) + 1;
                        m_rec  = (w & 31) + 1;
                        m_rdy  = fast && w[6];
                        m_phase = 1;
                    end
                end
                1: begin
                    if (m_rdy && !iordy[m_ch]) begin
                        m_stall++;
                        if (m_stall == STRETCH) begin
                            m_tmo = 1; m_phase = 2; m_left = m_rec;
                        end
                    end else begin
                        m_left--;
                        if (m_left == 0) begin m_phase = 2; m_left = m_rec; end
                    end
                end
                2: begin
                    m_left--;
                    if (m_left == 0) m_phase = 3;
                end
                default: m_phase = 0;
            endcase
            if (cfg_we) begin
                if (cfg_addr == 8'h40) m_ctrl = cfg_wdata & 32'h33;
                for (int i = 0; i < 4; i++)
                    if (cfg_addr == 8'h44 + 8'(4 * i)) m_tim[i] = cfg_wdata[15:0] & 16'h1F5F;
            end
            for (int c = 0; c < 2; c++) if (chan_rst[c]) m_ctrl[c * 4 + 1] = 0;
        end
    end

    // per-cycle comparison against the model (R8, R9, R5, R7)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit [1:0] e_rd, e_wr;
            for (int c = 0; c < 2; c++) begin
                e_rd[c] = !(m_phase == 1 && m_ch == c && !m_wr);
                e_wr[c] = !(m_phase == 1 && m_ch == c && m_wr);
            end
            check_eq("R8", "rd_n vs model", int'(rd_n), int'(e_rd));
            check_eq("R8", "wr_n vs model", int'(wr_n), int'(e_wr));
            check_eq("R9", "busy vs model", int'(busy), int'(m_phase != 0));
            check_eq("R9", "done vs model", int'(done), int'(m_phase == 3));
            check_eq("R5", "err vs model", int'(err), int'(m_phase == 3 && m_err));
            check_eq("R7", "timeout vs model", int'(timeout), int'(m_phase == 3 && m_tmo));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_write(input int addr, input int data);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = addr[7:0]; cfg_wdata = data;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input int addr, input int exp, input string req);
        @(negedge clk); #1;
        cfg_addr = addr[7:0];
        #1;
        check_eq(req, $sformatf("readback 0x%0h", addr), int'(cfg_rdata), exp);
    endtask

    task automatic pulse_chan_rst(input int ch);
        @(negedge clk); #1;
        chan_rst[ch] = 1'b1;
        @(negedge clk); #1;
        chan_rst = 2'b00;
    endtask

    task automatic access(input int ch, input int drv, input bit wr, input int stall,
                          input bit poke_busy, input bit poke_cfg,
                          input int exp_low, input int exp_lat,
                          input bit exp_err, input bit exp_tmo, input string req);
        int low = 0;
        int wrong = 0;
        int lat = -1;
        @(negedge clk); #1;
        if (stall > 0) iordy[ch] = 1'b0;
        req_valid = 1'b1; req_chan = ch[0]; req_drive = drv[0]; req_write = wr;
        for (int i = 1; i <= 2000; i++) begin
            bit mine;
            @(negedge clk); #1;
            req_valid = 1'b0; cfg_we = 1'b0;
            mine = wr ? !wr_n[ch] : !rd_n[ch];
            if (mine) low++;
            wrong += $countones(~{rd_n, wr_n}) - int'(mine);
            if (done) begin
                lat = i - 1;
                check_eq(req, "err at done", int'(err), int'(exp_err));
                check_eq(req, "timeout at done", int'(timeout), int'(exp_tmo));
                break;
            end
            if (i == stall + 1) iordy[ch] = 1'b1;
            if (poke_busy && i == 2) begin
                req_valid = 1'b1; req_chan = ~ch[0]; req_write = ~wr;
            end
            if (poke_cfg && i == 2) begin
                cfg_we = 1'b1; cfg_addr = 8'h44 + 8'(8 * ch + 4 * drv); cfg_wdata = '0;
            end
        end
        iordy = 2'b11;
        check_eq(req, "strobe low cycles", low, exp_low);
        check_eq(req, "cycles before done", lat, exp_lat);
        check_eq(req, "foreign strobe cycles", wrong, 0);
        @(negedge clk); #1;
        check_eq(req, "busy after done", int'(busy), 0);
        check_eq(req, "strobes after done", int'({rd_n, wr_n}), 15);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R2 reset values and idle outputs (R8)
        cfg_check('h40, 'h0, "R2");
        cfg_check('h44, 'h0909, "R2");
        cfg_check('h50, 'h0909, "R2");
        check_eq("R8", "idle strobes after reset", int'({rd_n, wr_n}), 15);
        check_eq("R9", "idle busy after reset", int'(busy), 0);

        // R5 both channels disabled
        access(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R5");
        cfg_write('h40, 'h10);
        access(0, 1, 1, 0, 0, 0, 0, 0, 1, 0, "R5");

        // R3 channel 1 enabled, slow default despite programmed word and ready
        cfg_write('h50, 'h0041);
        access(1, 1, 1, 4, 0, 0, 10, 20, 0, 0, "R3");

        // R2 field masking and offsets
        cfg_write('h40, 'hFFFF_FFFF);
        cfg_check('h40, 'h33, "R2");
        cfg_write('h48, 'hFFFF_FFFF);
        cfg_check('h48, 'h1F5F, "R2");

        // R1 phase lengths
        cfg_write('h44, 'h0203);
        cfg_write('h48, 'h0000);
        cfg_write('h4C, 'h1F1F);
        cfg_write('h50, 'h0541);
        access(0, 0, 0, 0, 0, 0, 3, 7, 0, 0, "R1");
        access(0, 1, 1, 0, 0, 0, 1, 2, 0, 0, "R1");
        access(1, 0, 1, 0, 0, 0, 32, 64, 0, 0, "R1");

        // R6 ready stretch, and ready ignored when bit 6 is clear
        access(1, 1, 0, 3, 0, 0, 9, 11, 0, 0, "R6");
        access(0, 0, 1, 3, 0, 0, 3, 7, 0, 0, "R6");

        // R7 stretch limit
        access(1, 1, 0, 300, 0, 0, 256, 258, 0, 1, "R7");

        // R9 request while busy ignored; R10 timing captured at acceptance
        access(0, 0, 0, 0, 1, 0, 3, 7, 0, 0, "R9");
        access(0, 0, 1, 0, 0, 1, 3, 7, 0, 0, "R10");
        cfg_check('h44, 'h0, "R10");

        // R4 channel reset clears only that channel's programmed-timing bit
        pulse_chan_rst(1);
        cfg_check('h40, 'h13, "R4");
        access(1, 1, 0, 4, 0, 0, 10, 20, 0, 0, "R4");
        access(0, 1, 0, 0, 0, 0, 1, 2, 0, 0, "R4");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule